// File: doc/BRIEF.md
# Hidden Address Pointer Update Unit

This block keeps the 16-bit hidden address register of an 8-bit processor core. The instruction decoder calls it once per finished instruction. It supplies a five-bit class code and the operand values the instruction used: register pairs, the accumulator, the immediates, the stack word, and the condition and repeat outcomes. On that clock edge the block loads the register with a value chosen by the class.

Some classes never touch the register. They hold it, as do unassigned codes and cycles without a strobe. The rules cover several kinds of update:

- plain address-plus-one loads;
- a mixed form that places the accumulator in the high byte beside an incremented low byte whose carry is dropped;
- branch targets that load only when the branch is taken;
- block operations that step the current value up or down, or that load the repeat address PC + 1.

Two bits of the register are copied out continuously as the undocumented flag bits 5 and 3. A bit test on (HL) reveals these flags.

The decoder alone works out the condition and repeat flags. An unconditional return or jump arrives with `cond_ok` high. DJNZ arrives with `cond_ok` equal to "B after the step is nonzero". A compare repeat arrives with `rpt_on` equal to "BC after the step is nonzero and A differs from the byte read". Single-step block instructions arrive with `rpt_on` low.

Top module: `wz_ptr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `ptr_q` to 0x0000. With `ptr_q` at 0x0000, both flag outputs are 0.
- R2: `ptr_q` keeps its value when `upd_vld` is low, whatever the class. It also keeps its value for the hold code 0 and for the unassigned codes 27 to 31.
- R3: Class 1, the indexed memory access, loads `idx_val` plus `disp8` sign-extended to 16 bits. The sum wraps modulo 2^16.
- R4: The loads of A from (BC), (DE) and (nn) set `ptr_q` to the address plus one, wrapping modulo 2^16. These are class 2 (`bc_pre`+1), class 3 (`de_val`+1) and class 4 (`imm16`+1). Class 4 also covers 16-bit pair loads and stores at (nn).
- R5: Classes 5 to 8 use the mixed form. The high byte becomes `acc`. The low byte becomes the source low byte plus one modulo 256, and nothing carries into the high byte. The sources are the low byte of `bc_pre` (class 5), of `de_val` (class 6), of `imm16` (class 7), and `imm8` (class 8, output to an immediate port).
- R6: Class 9, input from an immediate port, loads the 16-bit value {`acc`,`imm8`} plus one. The carry propagates into the high byte.
- R7: Four classes load a word without regard to `cond_ok`. Class 10, the absolute jump or call, loads `imm16`. Class 14, the restart, loads {0x00,`imm8`}. Class 15, the stack exchange, loads `stk_word`. Class 12, the plain return, loads `stk_word`.
- R8: Class 11, the relative branch, loads `pc_pre` + 2 + sign-extended `disp8` only when `cond_ok` is high. Class 13, the conditional return, loads `stk_word` only when `cond_ok` is high. With `cond_ok` low, both classes hold.
- R9: Class 21 (compare-increment) adds one to the current `ptr_q`. Class 22 (compare-decrement) subtracts one from it. With `rpt_on` high, either class loads `pc_pre`+1 instead.
- R10: Class 20, the block move, loads `pc_pre`+1 when `rpt_on` is high and otherwise holds.
- R11: The block input classes use `bc_pre`: class 23 loads `bc_pre`+1 and class 24 loads `bc_pre`-1. The block output classes use `bc_post`: class 25 loads `bc_post`+1 and class 26 loads `bc_post`-1. With `rpt_on` high, all four load `pc_pre`+1.
- R12: Class 16 (port access through C) loads `bc_pre`+1. Classes 17 (16-bit arithmetic on HL) and 19 (digit rotate) load `hl_val`+1. Class 18 (16-bit add on an index register) loads `idx_val`+1.
- R13: `xf5` always equals bit 13 of `ptr_q` and `xf3` always equals bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_vld | input | 1 | Instruction-complete strobe |
| upd_cls | input | 5 | Instruction class code |
| bc_pre | input | 16 | BC before the instruction |
| bc_post | input | 16 | BC after the instruction |
| de_val | input | 16 | DE before the instruction |
| hl_val | input | 16 | HL before the instruction |
| idx_val | input | 16 | Selected index register before the instruction |
| pc_pre | input | 16 | Address of the instruction |
| acc | input | 8 | Accumulator |
| imm8 | input | 8 | Immediate byte or restart vector |
| imm16 | input | 16 | Immediate word |
| disp8 | input | 8 | Signed displacement |
| stk_word | input | 16 | Word popped or read from the stack |
| cond_ok | input | 1 | Condition met or branch taken |
| rpt_on | input | 1 | Block instruction repeats |
| ptr_q | output | 16 | Hidden address register |
| xf5 | output | 1 | Flag bit 5 image (register bit 13) |
| xf3 | output | 1 | Flag bit 3 image (register bit 11) |

## Verification
Some properties are checked on every cycle:

- the register is stable while the strobe is low;
- a not-taken relative branch leaves it alone;
- an absolute jump always lands on the word;
- a compare-increment without repeat advances by exactly one;
- a store of A places the accumulator in the high byte;
- reset clears the register.

The directed scenarios are needed for the wrap-around corners: the dropped carry of the mixed form against the propagated carry of the port input, and the 0xFFFF/0x0000 crossings. They are also needed to show that the block classes take their base from the correct BC copy, and that negative displacements and the flag taps come out right.

// File: rtl/wz_pkg.sv
package wz_pkg;

    localparam int WZ_AW = 16;

    typedef enum logic [4:0] {
        CLS_HOLD      = 5'd0,
        CLS_IDX_MEM   = 5'd1,
        CLS_LDA_BC    = 5'd2,
        CLS_LDA_DE    = 5'd3,
        CLS_ABS_RD    = 5'd4,
        CLS_STA_BC    = 5'd5,
        CLS_STA_DE    = 5'd6,
        CLS_STA_NN    = 5'd7,
        CLS_OUT_IMM   = 5'd8,
        CLS_IN_IMM    = 5'd9,
        CLS_JP_ABS    = 5'd10,
        CLS_JR_REL    = 5'd11,
        CLS_RET_ALW   = 5'd12,
        CLS_RET_CC    = 5'd13,
        CLS_RST       = 5'd14,
        CLS_EX_SP     = 5'd15,
        CLS_PORT_C    = 5'd16,
        CLS_ALU16_HL  = 5'd17,
        CLS_ALU16_IDX = 5'd18,
        CLS_DIGIT_ROT = 5'd19,
        CLS_BLK_MOVE  = 5'd20,
        CLS_BLK_CPI   = 5'd21,
        CLS_BLK_CPD   = 5'd22,
        CLS_BLK_INI   = 5'd23,
        CLS_BLK_IND   = 5'd24,
        CLS_BLK_OUTI  = 5'd25,
        CLS_BLK_OUTD  = 5'd26
    } wz_cls_e;

    // Index of each mixed-form source inside the candidate array
    localparam int MIX_BC  = 0;
    localparam int MIX_DE  = 1;
    localparam int MIX_NN  = 2;
    localparam int MIX_N   = 3;
    localparam int MIX_CNT = 4;

endpackage

// File: rtl/wz_sum_unit.sv
module wz_sum_unit #(
    parameter int AW = wz_pkg::WZ_AW
) (
    input  logic [AW-1:0]   cur,
    input  logic [AW-1:0]   bc_pre,
    input  logic [AW-1:0]   bc_post,
    input  logic [AW-1:0]   de_val,
    input  logic [AW-1:0]   hl_val,
    input  logic [AW-1:0]   idx_val,
    input  logic [AW-1:0]   pc_pre,
    input  logic [AW/2-1:0] acc,
    input  logic [AW/2-1:0] imm8,
    input  logic [AW-1:0]   imm16,
    input  logic [AW/2-1:0] disp8,
    output logic [AW-1:0]   cur_inc,
    output logic [AW-1:0]   cur_dec,
    output logic [AW-1:0]   pc_rep,
    output logic [AW-1:0]   pc_rel,
    output logic [AW-1:0]   idx_off,
    output logic [AW-1:0]   idx_inc,
    output logic [AW-1:0]   bcpre_inc,
    output logic [AW-1:0]   bcpre_dec,
    output logic [AW-1:0]   bcpost_inc,
    output logic [AW-1:0]   bcpost_dec,
    output logic [AW-1:0]   de_inc,
    output logic [AW-1:0]   hl_inc,
    output logic [AW-1:0]   imm16_inc,
    output logic [AW-1:0]   port_in,
    output logic [wz_pkg::MIX_CNT-1:0][AW-1:0] mix
);
    localparam int BW = AW / 2;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] disp_sx;
    logic [BW-1:0] lo_src [wz_pkg::MIX_CNT];

    assign disp_sx = {{(AW-BW){disp8[BW-1]}}, disp8};

    assign cur_inc    = cur + ONE;
    assign cur_dec    = cur - ONE;
    assign pc_rep     = pc_pre + ONE;
    assign pc_rel     = pc_pre + TWO + disp_sx;
    assign idx_off    = idx_val + disp_sx;
    assign idx_inc    = idx_val + ONE;
    assign bcpre_inc  = bc_pre + ONE;
    assign bcpre_dec  = bc_pre - ONE;
    assign bcpost_inc = bc_post + ONE;
    assign bcpost_dec = bc_post - ONE;
    assign de_inc     = de_val + ONE;
    assign hl_inc     = hl_val + ONE;
    assign imm16_inc  = imm16 + ONE;
    assign port_in    = {acc, imm8} + ONE;

    assign lo_src[wz_pkg::MIX_BC] = bc_pre[BW-1:0];
    assign lo_src[wz_pkg::MIX_DE] = de_val[BW-1:0];
    assign lo_src[wz_pkg::MIX_NN] = imm16[BW-1:0];
    assign lo_src[wz_pkg::MIX_N]  = imm8;

    // Mixed form: accumulator high, low byte incremented with carry dropped
    for (genvar g = 0; g < wz_pkg::MIX_CNT; g++) begin : g_mix
        assign mix[g] = {acc, lo_src[g] + BW'(1)};
    end

endmodule

// File: rtl/wz_next_sel.sv
module wz_next_sel #(
    parameter int AW = wz_pkg::WZ_AW
) (
    input  logic [4:0]      cls,
    input  logic            cond_ok,
    input  logic            rpt_on,
    input  logic [AW-1:0]   imm16,
    input  logic [AW/2-1:0] imm8,
    input  logic [AW-1:0]   stk_word,
    input  logic [AW-1:0]   cur_inc,
    input  logic [AW-1:0]   cur_dec,
    input  logic [AW-1:0]   pc_rep,
    input  logic [AW-1:0]   pc_rel,
    input  logic [AW-1:0]   idx_off,
    input  logic [AW-1:0]   idx_inc,
    input  logic [AW-1:0]   bcpre_inc,
    input  logic [AW-1:0]   bcpre_dec,
    input  logic [AW-1:0]   bcpost_inc,
    input  logic [AW-1:0]   bcpost_dec,
    input  logic [AW-1:0]   de_inc,
    input  logic [AW-1:0]   hl_inc,
    input  logic [AW-1:0]   imm16_inc,
    input  logic [AW-1:0]   port_in,
    input  logic [wz_pkg::MIX_CNT-1:0][AW-1:0] mix,
    output logic            load,
    output logic [AW-1:0]   nxt
);
    import wz_pkg::*;

    localparam int BW = AW / 2;

    wz_cls_e cls_e;
    assign cls_e = wz_cls_e'(cls);

    always_comb begin
        load = 1'b1;
        nxt  = '0;
        unique case (cls_e)
            CLS_IDX_MEM:   nxt = idx_off;
            CLS_LDA_BC:    nxt = bcpre_inc;
            CLS_LDA_DE:    nxt = de_inc;
            CLS_ABS_RD:    nxt = imm16_inc;
            CLS_STA_BC:    nxt = mix[MIX_BC];
            CLS_STA_DE:    nxt = mix[MIX_DE];
            CLS_STA_NN:    nxt = mix[MIX_NN];
            CLS_OUT_IMM:   nxt = mix[MIX_N];
            CLS_IN_IMM:    nxt = port_in;
            CLS_JP_ABS:    nxt = imm16;
            CLS_JR_REL: begin
                load = cond_ok;
                nxt  = pc_rel;
            end
            CLS_RET_ALW:   nxt = stk_word;
            CLS_RET_CC: begin
                load = cond_ok;
                nxt  = stk_word;
            end
            CLS_RST:       nxt = {{(AW-BW){1'b0}}, imm8};
            CLS_EX_SP:     nxt = stk_word;
            CLS_PORT_C:    nxt = bcpre_inc;
            CLS_ALU16_HL:  nxt = hl_inc;
            CLS_ALU16_IDX: nxt = idx_inc;
            CLS_DIGIT_ROT: nxt = hl_inc;
            CLS_BLK_MOVE: begin
                load = rpt_on;
                nxt  = pc_rep;
            end
            CLS_BLK_CPI:   nxt = rpt_on ? pc_rep : cur_inc;
            CLS_BLK_CPD:   nxt = rpt_on ? pc_rep : cur_dec;
            CLS_BLK_INI:   nxt = rpt_on ? pc_rep : bcpre_inc;
            CLS_BLK_IND:   nxt = rpt_on ? pc_rep : bcpre_dec;
            CLS_BLK_OUTI:  nxt = rpt_on ? pc_rep : bcpost_inc;
            CLS_BLK_OUTD:  nxt = rpt_on ? pc_rep : bcpost_dec;
            default: begin
                load = 1'b0;
                nxt  = '0;
            end
        endcase
    end

endmodule

// File: rtl/wz_hold_reg.sv
module wz_hold_reg #(
    parameter int AW = wz_pkg::WZ_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/wz_ptr_unit.sv
module wz_ptr_unit #(
    parameter int AW = wz_pkg::WZ_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd_vld,
    input  logic [4:0]      upd_cls,
    input  logic [AW-1:0]   bc_pre,
    input  logic [AW-1:0]   bc_post,
    input  logic [AW-1:0]   de_val,
    input  logic [AW-1:0]   hl_val,
    input  logic [AW-1:0]   idx_val,
    input  logic [AW-1:0]   pc_pre,
    input  logic [AW/2-1:0] acc,
    input  logic [AW/2-1:0] imm8,
    input  logic [AW-1:0]   imm16,
    input  logic [AW/2-1:0] disp8,
    input  logic [AW-1:0]   stk_word,
    input  logic            cond_ok,
    input  logic            rpt_on,
    output logic [AW-1:0]   ptr_q,
    output logic            xf5,
    output logic            xf3
);
    localparam int TAP5 = 13;
    localparam int TAP3 = 11;

    logic [AW-1:0] cur_inc, cur_dec, pc_rep, pc_rel, idx_off, idx_inc;
    logic [AW-1:0] bcpre_inc, bcpre_dec, bcpost_inc, bcpost_dec;
    logic [AW-1:0] de_inc, hl_inc, imm16_inc, port_in, nxt;
    logic [wz_pkg::MIX_CNT-1:0][AW-1:0] mix;
    logic          load;

    wz_sum_unit #(.AW(AW)) u_sum (
        .cur(ptr_q), .bc_pre(bc_pre), .bc_post(bc_post), .de_val(de_val),
        .hl_val(hl_val), .idx_val(idx_val), .pc_pre(pc_pre), .acc(acc),
        .imm8(imm8), .imm16(imm16), .disp8(disp8),
        .cur_inc(cur_inc), .cur_dec(cur_dec), .pc_rep(pc_rep), .pc_rel(pc_rel),
        .idx_off(idx_off), .idx_inc(idx_inc), .bcpre_inc(bcpre_inc),
        .bcpre_dec(bcpre_dec), .bcpost_inc(bcpost_inc), .bcpost_dec(bcpost_dec),
        .de_inc(de_inc), .hl_inc(hl_inc), .imm16_inc(imm16_inc),
        .port_in(port_in), .mix(mix)
    );

    wz_next_sel #(.AW(AW)) u_sel (
        .cls(upd_cls), .cond_ok(cond_ok), .rpt_on(rpt_on), .imm16(imm16),
        .imm8(imm8), .stk_word(stk_word), .cur_inc(cur_inc), .cur_dec(cur_dec),
        .pc_rep(pc_rep), .pc_rel(pc_rel), .idx_off(idx_off), .idx_inc(idx_inc),
        .bcpre_inc(bcpre_inc), .bcpre_dec(bcpre_dec), .bcpost_inc(bcpost_inc),
        .bcpost_dec(bcpost_dec), .de_inc(de_inc), .hl_inc(hl_inc),
        .imm16_inc(imm16_inc), .port_in(port_in), .mix(mix),
        .load(load), .nxt(nxt)
    );

    wz_hold_reg #(.AW(AW)) u_reg (
        .clk(clk), .rst(rst), .en(upd_vld & load), .d(nxt), .q(ptr_q)
    );

    assign xf5 = ptr_q[TAP5];
    assign xf3 = ptr_q[TAP3];

endmodule

// File: rtl/wz_ptr_unit_chk.sv
module wz_ptr_unit_chk #(
    parameter int AW = wz_pkg::WZ_AW
) (
    input logic            clk,
    input logic            rst,
    input logic            upd_vld,
    input logic [4:0]      upd_cls,
    input logic [AW/2-1:0] acc,
    input logic [AW-1:0]   imm16,
    input logic            cond_ok,
    input logic            rpt_on,
    input logic [AW-1:0]   ptr_q
);
    import wz_pkg::*;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ptr_q == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_vld |=> $stable(ptr_q));

    // R8
    untaken_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && upd_cls == CLS_JR_REL && !cond_ok) |=> $stable(ptr_q));

    // R7
    jump_word_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && upd_cls == CLS_JP_ABS) |=> (ptr_q == $past(imm16)));

    // R9
    cmp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && upd_cls == CLS_BLK_CPI && !rpt_on)
        |=> (ptr_q == $past(ptr_q) + AW'(1)));

    // R5
    store_high_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && upd_cls == CLS_STA_NN) |=> (ptr_q[AW-1:AW/2] == $past(acc)));

endmodule

bind wz_ptr_unit wz_ptr_unit_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .upd_vld(upd_vld), .upd_cls(upd_cls), .acc(acc),
    .imm16(imm16), .cond_ok(cond_ok), .rpt_on(rpt_on), .ptr_q(ptr_q)
);

// File: tb/wz_ptr_unit_bench.sv
module wz_ptr_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_vld = 1'b0;
    logic [4:0]  upd_cls = 5'd0;
    logic [15:0] bc_pre = '0, bc_post = '0, de_val = '0, hl_val = '0;
    logic [15:0] idx_val = '0, pc_pre = '0, imm16 = '0, stk_word = '0;
    logic [7:0]  acc = '0, imm8 = '0, disp8 = '0;
    logic        cond_ok = 1'b0, rpt_on = 1'b0;
    logic [15:0] ptr_q;
    logic        xf5, xf3;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wz_ptr_unit u_wz_ptr_unit (
        .clk(clk), .rst(rst), .upd_vld(upd_vld), .upd_cls(upd_cls),
        .bc_pre(bc_pre), .bc_post(bc_post), .de_val(de_val), .hl_val(hl_val),
        .idx_val(idx_val), .pc_pre(pc_pre), .acc(acc), .imm8(imm8),
        .imm16(imm16), .disp8(disp8), .stk_word(stk_word), .cond_ok(cond_ok),
        .rpt_on(rpt_on), .ptr_q(ptr_q), .xf5(xf5), .xf3(xf3)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one strobe at the falling edge; the result is visible at the next falling edge
    task automatic step(input logic [4:0] c);
        upd_cls = c;
        upd_vld = 1'b1;
        @(negedge clk);
        upd_vld = 1'b0;
        cond_ok = 1'b0;
        rpt_on  = 1'b0;
    endtask

    task automatic preset(input logic [15:0] v);
        imm16 = v;
        step(5'd10);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset value", ptr_q, 16'h0000);
        chk("R1 flags at zero", {14'd0, xf5, xf3}, 16'h0000);
    endtask

    task automatic t_indexed;
        idx_val = 16'h1000; disp8 = 8'hF0; step(5'd1);
        chk("R3 negative displacement", ptr_q, 16'h0FF0);
        disp8 = 8'h7F; step(5'd1);
        chk("R3 positive displacement", ptr_q, 16'h107F);
    endtask

    task automatic t_loads;
        bc_pre = 16'hFFFF; step(5'd2);
        chk("R4 load via BC wraps", ptr_q, 16'h0000);
        de_val = 16'h1234; step(5'd3);
        chk("R4 load via DE", ptr_q, 16'h1235);
        imm16 = 16'h40FF; step(5'd4);
        chk("R4 load via nn carries", ptr_q, 16'h4100);
    endtask

    task automatic t_mixed;
        acc = 8'h5A; imm16 = 16'h12FF; step(5'd7);
        chk("R5 store nn drops carry", ptr_q, 16'h5A00);
        acc = 8'h11; bc_pre = 16'h3380; step(5'd5);
        chk("R5 store via BC", ptr_q, 16'h1181);
        acc = 8'h77; de_val = 16'hABFF; step(5'd6);
        chk("R5 store via DE", ptr_q, 16'h7700);
        acc = 8'h22; imm8 = 8'hFF; step(5'd8);
        chk("R5 output to port n", ptr_q, 16'h2200);
    endtask

    task automatic t_port_in;
        acc = 8'h22; imm8 = 8'hFF; step(5'd9);
        chk("R6 input carries into high", ptr_q, 16'h2300);
        acc = 8'hFF; imm8 = 8'hFF; step(5'd9);
        chk("R6 input wraps", ptr_q, 16'h0000);
    endtask

    task automatic t_words;
        imm16 = 16'hBEEF; cond_ok = 1'b0; step(5'd10);
        chk("R7 jump ignores condition", ptr_q, 16'hBEEF);
        imm8 = 8'h38; step(5'd14);
        chk("R7 restart vector", ptr_q, 16'h0038);
        stk_word = 16'h2468; step(5'd15);
        chk("R7 stack exchange", ptr_q, 16'h2468);
        stk_word = 16'h1357; cond_ok = 1'b0; step(5'd12);
        chk("R7 plain return", ptr_q, 16'h1357);
    endtask

    task automatic t_branch;
        preset(16'h5555);
        pc_pre = 16'h8000; disp8 = 8'hFE; cond_ok = 1'b0; step(5'd11);
        chk("R8 branch not taken holds", ptr_q, 16'h5555);
        cond_ok = 1'b1; step(5'd11);
        chk("R8 branch back to self", ptr_q, 16'h8000);
        disp8 = 8'h10; cond_ok = 1'b1; step(5'd11);
        chk("R8 branch forward", ptr_q, 16'h8012);
        stk_word = 16'h0F0F; cond_ok = 1'b0; step(5'd13);
        chk("R8 return not met holds", ptr_q, 16'h8012);
        cond_ok = 1'b1; step(5'd13);
        chk("R8 return met", ptr_q, 16'h0F0F);
    endtask

    task automatic t_compare;
        preset(16'hFFFF);
        step(5'd21);
        chk("R9 compare-increment wraps", ptr_q, 16'h0000);
        step(5'd22);
        chk("R9 compare-decrement wraps", ptr_q, 16'hFFFF);
        pc_pre = 16'h0200; rpt_on = 1'b1; step(5'd21);
        chk("R9 increment repeat", ptr_q, 16'h0201);
        pc_pre = 16'h0300; rpt_on = 1'b1; step(5'd22);
        chk("R9 decrement repeat", ptr_q, 16'h0301);
    endtask

    task automatic t_move;
        preset(16'h4444);
        pc_pre = 16'h0700; rpt_on = 1'b0; step(5'd20);
        chk("R10 move no repeat holds", ptr_q, 16'h4444);
        rpt_on = 1'b1; step(5'd20);
        chk("R10 move repeat", ptr_q, 16'h0701);
    endtask

    task automatic t_block_io;
        bc_pre = 16'h0100; bc_post = 16'h00FF;
        step(5'd23); chk("R11 input step up", ptr_q, 16'h0101);
        step(5'd24); chk("R11 input step down", ptr_q, 16'h00FF);
        step(5'd25); chk("R11 output step up", ptr_q, 16'h0100);
        step(5'd26); chk("R11 output step down", ptr_q, 16'h00FE);
        pc_pre = 16'h0900; rpt_on = 1'b1; step(5'd24);
        chk("R11 input repeat", ptr_q, 16'h0901);
        pc_pre = 16'h0A00; rpt_on = 1'b1; step(5'd25);
        chk("R11 output repeat", ptr_q, 16'h0A01);
    endtask

    task automatic t_arith;
        bc_pre = 16'h0FFF; step(5'd16);
        chk("R12 port via C", ptr_q, 16'h1000);
        hl_val = 16'h2222; step(5'd17);
        chk("R12 16-bit HL", ptr_q, 16'h2223);
        idx_val = 16'hFFFF; step(5'd18);
        chk("R12 16-bit index", ptr_q, 16'h0000);
        hl_val = 16'h6000; step(5'd19);
        chk("R12 digit rotate", ptr_q, 16'h6001);
    endtask

    task automatic t_hold;
        preset(16'h3C3C);
        imm16 = 16'h1111; upd_cls = 5'd10; upd_vld = 1'b0;
        @(negedge clk);
        chk("R2 no strobe holds", ptr_q, 16'h3C3C);
        step(5'd29);
        chk("R2 unassigned code holds", ptr_q, 16'h3C3C);
        step(5'd0);
        chk("R2 hold code", ptr_q, 16'h3C3C);
    endtask

    task automatic t_flags;
        preset(16'h2800);
        chk("R13 both taps set", {14'd0, xf5, xf3}, 16'h0003);
        preset(16'h2000);
        chk("R13 bit 13 only", {14'd0, xf5, xf3}, 16'h0002);
        preset(16'hD7FF);
        chk("R13 taps clear", {14'd0, xf5, xf3}, 16'h0000);
    endtask

    task automatic t_reset_mid;
        preset(16'h9999);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset after use", ptr_q, 16'h0000);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_indexed();
        t_loads();
        t_mixed();
        t_port_in();
        t_words();
        t_branch();
        t_compare();
        t_move();
        t_block_io();
        t_arith();
        t_hold();
        t_flags();
        t_reset_mid();
        finish_run();
    end

endmodule